// File: doc/BRIEF.md
# HDLC Byte-Stuffing Frame Encoder

This block turns a message, presented one byte at a time on a valid/ready input with an end-of-message marker, into a framed byte stream for a UART transmitter. Each frame opens with a flag byte (0x7E), then carries the payload. Any payload byte that would be confused with framing (0x7E or 0x7D) is replaced by an escape byte followed by a modified copy. An 8-bit checksum of the raw payload comes next, escaped by the same rule, and a second flag byte closes the frame.

The output side is a single holding register with valid/ready, meant to feed a UART serializer directly. The input is throttled through its ready signal. Ready is low while the encoder sends a byte of its own: the opening flag, the second byte of an escape pair, the checksum and the closing flag. A message with no payload bytes is signalled by one input beat with the empty marker set. It still yields a complete frame that holds only the checksum of nothing.

Top module: `hdlc_frame_encoder`

## Requirements
- R1: Every frame begins with one 0x7E byte, emitted before any payload byte, and ends with one 0x7E byte after the checksum.
- R2: A payload byte equal to 0x7E or 0x7D is emitted as 0x7D followed by the byte XOR 0x20. Every other payload byte is emitted unchanged, in input order.
- R3: The checksum is a reflected CRC-8 with polynomial x^8+x^5+x^4+1 (0x8C in LSB-first form) and start value 0xFF. Each raw payload byte is shifted in LSB first. Flags and escape bytes are not included. For payload 2F 00 05 01 FF FF 00 7E 7D the checksum is 0x7E.
- R4: The checksum byte follows the last payload byte and is escaped by the rule of R2.
- R5: The checksum restarts at 0xFF for every frame, so frames sent back to back encode independently.
- R6: An accepted input beat with in_empty=1 ends the message without contributing a byte, and in_data and in_last are ignored on that beat. A message made of only that beat produces 7E FF 7E.
- R7: in_ready is high only when the encoder is between payload bytes of an open frame and its output register can take a byte. In particular, in_ready is low in the cycle after a reserved payload byte is accepted.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: During reset out_valid and in_ready are low.
- R10: With any pattern of out_ready stalls, the output byte sequence is exactly the sequence defined by R1 to R6, with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | in_data / in_last / in_empty are valid |
| in_last | input | 1 | This byte is the last byte of the message |
| in_empty | input | 1 | This beat ends the message and carries no byte |
| in_ready | output | 1 | Encoder accepts the input beat this cycle |
| out_data | output | 8 | Framed byte toward the UART |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | UART takes out_data this cycle |

## Verification
All 256 one-byte messages are swept, so the escape decision is checked for every value, and so is the checksum escape whenever a one-byte CRC lands on 0x7E or 0x7D. Two-byte messages built from the reserved values and their neighbours (0x5D, 0x5E, 0x7C, 0x7F and others) separate a correct compare from an off-by-one compare, and show back-to-back escape pairs keeping their order. The worked example and the empty message pin the checksum's start value and the frame delimiters. Random-length messages, sent under random and periodic out_ready stalls, show that no byte is lost or duplicated when the holding register is stalled at each state of the frame.

// File: rtl/hdlc_enc_pkg.sv
// Package: shared constants and state encoding for the HDLC frame encoder.
// Assumes 8-bit bytes; the reserved values are fixed by the framing rule.
package hdlc_enc_pkg;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [7:0]  ESC_BYTE  = 8'h7D;
    localparam logic [7:0]  FLIP_MASK = 8'h20;
    localparam logic [7:0]  CRC_POLY  = 8'h8C;   // reflected x^8+x^5+x^4+1
    localparam logic [7:0]  CRC_SEED  = 8'hFF;

    // Frame sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,   // waiting for the first beat of a message
        ST_DATA    = 3'd1,   // accepting payload beats
        ST_ESC2    = 3'd2,   // emitting second byte of a payload escape
        ST_CRC     = 3'd3,   // emitting checksum (or its escape lead)
        ST_CRC_ESC = 3'd4,   // emitting second byte of a checksum escape
        ST_CLOSE   = 3'd5    // emitting the closing flag
    } enc_state_t;

endpackage

// File: rtl/hdlc_crc8.sv
// Module: hdlc_crc8
// Running reflected CRC-8. 'restart' loads the seed, 'update' folds one
// byte in LSB first. Assumes restart and update are never high together.
module hdlc_crc8 #(
    parameter int         W    = 8,
    parameter logic [7:0] POLY = 8'h8C,
    parameter logic [7:0] SEED = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         update,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_next;

    // Purpose: compute the register value after one byte, bit by bit.
    always_comb begin
        logic [W-1:0] acc;
        logic         mix;
        acc = crc_q;
        for (int b = 0; b < W; b++) begin
            mix = acc[0] ^ din[b];
            acc = acc >> 1;
            if (mix) begin
                acc = acc ^ POLY;
            end
        end
        crc_next = acc;
    end

    // Purpose: hold the running checksum across a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (restart) begin
            crc_q <= SEED;
        end else if (update) begin
            crc_q <= crc_next;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/hdlc_escape.sv
// Module: hdlc_escape
// Classifies a byte as reserved (flag or escape value) and gives the
// substitute byte sent after the escape lead. Purely combinational.
module hdlc_escape #(
    parameter int         W    = 8,
    parameter logic [7:0] FLAG = 8'h7E,
    parameter logic [7:0] ESC  = 8'h7D,
    parameter logic [7:0] FLIP = 8'h20
) (
    input  logic [W-1:0] din,
    output logic         reserved,
    output logic [W-1:0] substitute
);

    // Purpose: detect the two values that must not travel as-is.
    always_comb begin
        reserved   = (din == FLAG) || (din == ESC);
        substitute = din ^ FLIP;
    end

endmodule

// File: rtl/hdlc_hold_reg.sv
// Module: hdlc_hold_reg
// One-entry output register with valid/ready. 'slot_free' tells the
// producer a load this cycle will not overwrite an untaken byte.
// Assumes 'load' is asserted only when slot_free is high.
module hdlc_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         slot_free
);

    logic         vld_q;
    logic [W-1:0] dat_q;

    // Purpose: the slot is free when empty or being drained this cycle.
    always_comb begin
        slot_free = !vld_q || out_ready;
    end

    // Purpose: keep the byte until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (load) begin
            vld_q <= 1'b1;
            dat_q <= din;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

endmodule

// File: rtl/hdlc_frame_encoder.sv
// Module: hdlc_frame_encoder (top)
// Frames a valid/ready byte stream: opening flag, escaped payload,
// escaped reflected CRC-8 of the raw payload, closing flag. One output
// byte per cycle at most; input is stalled whenever the encoder inserts
// a byte of its own. Assumes input fields stay stable while in_valid is
// high and in_ready is low.
module hdlc_frame_encoder
    import hdlc_enc_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    input  logic         in_last,
    input  logic         in_empty,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);

    enc_state_t   state_q, state_d;
    logic [W-1:0] pend_q, pend_d;        // second byte of a pending escape pair
    logic         pend_last_q, pend_last_d;

    logic         slot_free;
    logic         ld;
    logic [W-1:0] ld_byte;
    logic         crc_restart;
    logic         crc_update;
    logic [W-1:0] crc_val;

    logic         in_rsv;
    logic [W-1:0] in_sub;
    logic         crc_rsv;
    logic [W-1:0] crc_sub;

    logic         beat;

    // Payload byte classifier.
    hdlc_escape #(.W(W), .FLAG(FLAG_BYTE), .ESC(ESC_BYTE), .FLIP(FLIP_MASK)) u_esc_in (
        .din        (in_data),
        .reserved   (in_rsv),
        .substitute (in_sub)
    );

    // Checksum byte classifier.
    hdlc_escape #(.W(W), .FLAG(FLAG_BYTE), .ESC(ESC_BYTE), .FLIP(FLIP_MASK)) u_esc_crc (
        .din        (crc_val),
        .reserved   (crc_rsv),
        .substitute (crc_sub)
    );

    hdlc_crc8 #(.W(W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .update  (crc_update),
        .din     (in_data),
        .crc     (crc_val)
    );

    hdlc_hold_reg #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .din       (ld_byte),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .slot_free (slot_free)
    );

    // Purpose: input is taken only between payload bytes with room at the output.
    always_comb begin
        in_ready = (state_q == ST_DATA) && slot_free;
        beat     = in_ready && in_valid;
    end

    // Purpose: choose the next output byte and the next frame state.
    always_comb begin
        state_d     = state_q;
        pend_d      = pend_q;
        pend_last_d = pend_last_q;
        ld          = 1'b0;
        ld_byte     = FLAG_BYTE;
        crc_restart = 1'b0;
        crc_update  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && slot_free) begin
                    ld          = 1'b1;
                    ld_byte     = FLAG_BYTE;
                    crc_restart = 1'b1;
                    state_d     = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat) begin
                    if (in_empty) begin
                        state_d = ST_CRC;
                    end else begin
                        crc_update = 1'b1;
                        ld         = 1'b1;
                        if (in_rsv) begin
                            ld_byte     = ESC_BYTE;
                            pend_d      = in_sub;
                            pend_last_d = in_last;
                            state_d     = ST_ESC2;
                        end else begin
                            ld_byte = in_data;
                            state_d = in_last ? ST_CRC : ST_DATA;
                        end
                    end
                end
            end
            ST_ESC2: begin
                if (slot_free) begin
                    ld      = 1'b1;
                    ld_byte = pend_q;
                    state_d = pend_last_q ? ST_CRC : ST_DATA;
                end
            end
            ST_CRC: begin
                if (slot_free) begin
                    ld = 1'b1;
                    if (crc_rsv) begin
                        ld_byte = ESC_BYTE;
                        pend_d  = crc_sub;
                        state_d = ST_CRC_ESC;
                    end else begin
                        ld_byte = crc_val;
                        state_d = ST_CLOSE;
                    end
                end
            end
            ST_CRC_ESC: begin
                if (slot_free) begin
                    ld      = 1'b1;
                    ld_byte = pend_q;
                    state_d = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (slot_free) begin
                    ld      = 1'b1;
                    ld_byte = FLAG_BYTE;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Purpose: register frame state and the pending escape byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_q      <= '0;
            pend_last_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            pend_q      <= pend_d;
            pend_last_q <= pend_last_d;
        end
    end

endmodule

// File: rtl/hdlc_frame_encoder_chk.sv
// Module: hdlc_frame_encoder_chk
// Port-level protocol checks for the frame encoder, attached by bind.
module hdlc_frame_encoder_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] in_data,
    input logic         in_valid,
    input logic         in_empty,
    input logic         in_ready,
    input logic [W-1:0] out_data,
    input logic         out_valid,
    input logic         out_ready
);

    logic in_rsv_taken;
    assign in_rsv_taken = in_valid && in_ready && !in_empty &&
                          ((in_data == 8'h7E) || (in_data == 8'h7D));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2
    esc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == 8'h7D) |=>
            (out_valid && (out_data == 8'h5E || out_data == 8'h5D)));

    // R2
    esc_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rsv_taken |=> (out_valid && out_data == 8'h7D));

    // R7
    esc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rsv_taken |=> !in_ready);

    // R7
    ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !in_ready));

endmodule

bind hdlc_frame_encoder hdlc_frame_encoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_empty  (in_empty),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/hdlc_frame_encoder_test.sv
module hdlc_frame_encoder_test;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_empty = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    int cycle = 0;
    bq_t got_q;

    always #5 clk = ~clk;

    hdlc_frame_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_empty  (in_empty),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    // Reference checksum: XOR the byte in, then eight shift/reduce steps.
    function automatic logic [7:0] ref_crc(input bq_t m);
        logic [7:0] c = 8'hFF;
        foreach (m[i]) begin
            c = c ^ m[i];
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
        end
        return c;
    endfunction

    function automatic void put_esc(ref bq_t q, input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            q.push_back(8'h7D);
            q.push_back(b ^ 8'h20);
        end else begin
            q.push_back(b);
        end
    endfunction

    function automatic bq_t ref_frame(input bq_t m);
        bq_t q;
        q.push_back(8'h7E);
        foreach (m[i]) put_esc(q, m[i]);
        put_esc(q, ref_crc(m));
        q.push_back(8'h7E);
        return q;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Consumer readiness pattern, changed just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = $urandom_range(0, 1) == 1;
            default: out_ready = (cycle % 3) != 0;
        endcase
    end

    // Monitor: collect bytes and check stall behaviour between edges.
    logic       p_stall = 1'b0;
    logic [7:0] p_data = 8'h00;
    logic       p_rsv = 1'b0;
    always @(negedge clk) begin
        cycle++;
        if (rst_n) begin
            if (p_stall) begin
                // R8: held byte stays put under backpressure
                check(out_valid && out_data == p_data, "R8", "held byte",
                      {55'd0, out_valid, out_data}, {55'd0, 1'b1, p_data});
            end
            if (p_rsv) begin
                // R7: no input taken while the escape pair completes
                check(!in_ready, "R7", "stall after reserved byte", in_ready, 0);
            end
            if (out_valid && out_ready) got_q.push_back(out_data);
            p_stall = out_valid && !out_ready;
            p_data  = out_data;
            p_rsv   = in_valid && in_ready && !in_empty &&
                      (in_data == 8'h7E || in_data == 8'h7D);
        end
        if (cycle > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycle);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic drive_beat(input logic [7:0] d, input bit last, input bit empty);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        in_empty = empty;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input bq_t m, input bit empty_msg, input string req);
        bq_t exp;
        int  t;
        bit  ok;
        exp = ref_frame(m);
        got_q.delete();
        @(posedge clk);
        #1;
        if (empty_msg) begin
            drive_beat(8'h7E, 1'b0, 1'b1);   // in_data/in_last must be ignored
        end else begin
            foreach (m[i]) drive_beat(m[i], i == m.size() - 1, 1'b0);
        end
        t = 0;
        while (got_q.size() < exp.size() && t < 200) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        ok = (got_q.size() == exp.size());
        if (ok) foreach (exp[i]) if (got_q[i] != exp[i]) ok = 0;
        if (!ok) begin
            checks++;
            errors++;
            $display("FAIL %s frame of %0d bytes: actual=%p expected=%p", req, m.size(), got_q, exp);
        end else begin
            checks++;
        end
    endtask

    initial begin
        bq_t ex;
        bq_t ex_frame;
        bq_t m;
        logic [7:0] pick[10] = '{8'h00, 8'h20, 8'h5D, 8'h5E, 8'h7C,
                                 8'h7D, 8'h7E, 8'h7F, 8'hFF, 8'hA5};

        // R9: reset state
        repeat (3) @(negedge clk);
        check(!out_valid, "R9", "out_valid in reset", out_valid, 0);
        check(!in_ready, "R9", "in_ready in reset", in_ready, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready, "R7", "in_ready idle", in_ready, 0);

        // R3: worked example checksum; R1 R2 R4: full encoded frame
        ex = '{8'h2F, 8'h00, 8'h05, 8'h01, 8'hFF, 8'hFF, 8'h00, 8'h7E, 8'h7D};
        check(ref_crc(ex) == 8'h7E, "R3", "example checksum", ref_crc(ex), 8'h7E);
        ex_frame = ref_frame(ex);
        check(ex_frame.size() == 15 && ex_frame[8] == 8'h7D && ex_frame[13] == 8'h5E,
              "R4", "example frame shape", ex_frame.size(), 15);
        run_frame(ex, 1'b0, "R1 R2 R3 R4 example");

        // R6: empty message
        m.delete();
        run_frame(m, 1'b1, "R6 empty");

        // R2 R4: every one-byte message
        for (int v = 0; v < 256; v++) begin
            m.delete();
            m.push_back(8'(v));
            run_frame(m, 1'b0, "R2 R4 single");
        end

        // R2 R5: all pairs from reserved values and neighbours, back to back
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                m.delete();
                m.push_back(pick[a]);
                m.push_back(pick[b]);
                run_frame(m, 1'b0, "R2 R5 pair");
            end
        end

        // R8 R10: random lengths under random and periodic stalls
        for (int mode = 1; mode <= 2; mode++) begin
            ready_mode = mode;
            for (int f = 0; f < 25; f++) begin
                m.delete();
                for (int i = 0; i < 1 + (f % 20); i++) begin
                    m.push_back((i % 4 == 1) ? 8'h7E - 8'($urandom_range(0, 1))
                                             : 8'($urandom_range(0, 255)));
                end
                run_frame(m, 1'b0, "R10 stalled");
            end
            m.delete();
            run_frame(m, 1'b1, "R6 R10 empty stalled");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule